// File: doc/BRIEF.md
# Memory Access Ordering Queue

This block sits between a processor's load/store path and a single main-memory request port. It holds up to eight pending operations, accepted in program order, and sends memory accesses out of order when that is safe. Ordinary cacheable accesses may overtake older entries that are held up. Two ordering operations travel through the same queue as entries. A light barrier keeps device-class accesses in order. A device-class access is one that carries the caching-inhibited bit or the guarded bit. A full barrier keeps every later access behind it until all earlier work has finished.

Each accepted operation is acknowledged once on the completion port with its identifier. A memory access is acknowledged after its memory response arrives. The light barrier is acknowledged once every older device-class access has a response. The full barrier is acknowledged once every older entry has been acknowledged. Responses from memory come back tagged with the slot number that the queue placed on the request. They may arrive in any order.

Top module: `ioq_order_queue`

## Requirements
- R1: During and right after reset the queue is empty: `in_ready` is 1, and `mem_req_valid` and `ack_valid` are 0.
- R2: An operation is taken on a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is 0 while all eight slots are in use. An offer made while `in_ready` is 0 leaves the queue unchanged. The operation is taken later, once a slot frees.
- R3: An access may be sent to memory from the cycle after it is accepted. At most one request is presented per cycle. When several accesses are eligible, the oldest one is presented. It leaves the queue's pending set on a cycle where `mem_req_valid` and `mem_req_ready` are both 1.
- R4: A cacheable access, with both attribute bits 0, is not held back by an older light barrier. It may reach memory before older device-class accesses that are held up.
- R5: A device-class access, with `in_inhib` or `in_guard` set, is never sent while an older light barrier is still in the queue.
- R6: A light barrier is acknowledged only after every older device-class access has received its memory response and no older full barrier remains. It then leaves the queue.
- R7: No access younger than a full barrier is sent while that barrier is queued. The full barrier is acknowledged only when it is the oldest entry.
- R8: Two accesses whose byte ranges overlap are sent in acceptance order, whatever their attributes. An access covers 2^size bytes starting at its naturally aligned address.
- R9: An access is acknowledged on the cycle after its memory response, or later if an older acknowledgement takes that cycle. The acknowledgement carries the access's identifier and the data the response returned. When several entries are ready, the oldest is acknowledged first.
- R10: Device-class stores separated by light barriers reach memory in program order, even while memory back-pressures the queue.
- R11: `in_kind` encoding: 0 is a memory access, 1 is a light barrier, and 2 or 3 is a full barrier. `ack_kind` reports the kind of the acknowledged entry with the same codes, where a full barrier reads back as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Processor offers an operation |
| in_ready | output | 1 | A free slot exists |
| in_kind | input | 2 | 0 access, 1 light barrier, 2/3 full barrier |
| in_addr | input | AW | Naturally aligned byte address |
| in_data | input | DW | Store data |
| in_size | input | 2 | Access size as log2 of the byte count |
| in_wr | input | 1 | 1 store, 0 load |
| in_inhib | input | 1 | Caching-inhibited attribute |
| in_guard | input | 1 | Guarded attribute |
| in_id | input | IDW | Identifier echoed on acknowledgement |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Request address |
| mem_req_data | output | DW | Request store data |
| mem_req_size | output | 2 | Request size code |
| mem_req_wr | output | 1 | Request direction |
| mem_req_tag | output | TW | Slot tag, returned with the response |
| mem_rsp_valid | input | 1 | Memory completion |
| mem_rsp_tag | input | TW | Tag of the completed request |
| mem_rsp_rdata | input | DW | Load data, or zero for stores |
| ack_valid | output | 1 | Completion to the processor |
| ack_id | output | IDW | Identifier of the completed operation |
| ack_kind | output | 2 | Kind of the completed operation |
| ack_rdata | output | DW | Returned data, zero for barriers |

## Verification
All results derive from registered state. An accepted entry can appear on the memory port one cycle after acceptance. A response turns into an acknowledgement one cycle later. A response that releases a light barrier makes the barrier's acknowledgement eligible on the next cycle. A freed slot is refilled no earlier than the cycle after its acknowledgement.

The bench drives each cycle's inputs just after the falling edge and compares every output against a behavioural queue model right after that. It then advances the model exactly as the coming rising edge will. Issue and acknowledgement order are logged, and directed scenarios compare those logs with the orders the ordering rules force.

// File: rtl/ioq_pkg.sv
package ioq_pkg;

    typedef enum logic [1:0] {
        K_ACC  = 2'd0,
        K_LBAR = 2'd1,
        K_SYNC = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        S_WAIT   = 2'd0,
        S_ISSUED = 2'd1,
        S_DONE   = 2'd2
    } st_e;

    typedef struct packed {
        kind_e      kind;
        st_e        st;
        logic [1:0] size;
        logic       wr;
        logic       strict;
    } meta_t;

    localparam meta_t META_RST = '{kind: K_ACC, st: S_WAIT, size: 2'd0, wr: 1'b0, strict: 1'b0};

    function automatic kind_e kind_decode(input logic [1:0] k);
        if (k == 2'd0) return K_ACC;
        if (k == 2'd1) return K_LBAR;
        return K_SYNC;
    endfunction

    // naturally aligned ranges overlap when they share the larger granule
    function automatic logic bytes_overlap(input logic [63:0] a, input logic [1:0] sa,
                                           input logic [63:0] b, input logic [1:0] sb);
        logic [1:0] sh;
        sh = (sa > sb) ? sa : sb;
        return (a >> sh) == (b >> sh);
    endfunction

endpackage

// File: rtl/ioq_age.sv
module ioq_age #(
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        valid_q,
    input  logic [N-1:0]        alloc,
    input  logic [N-1:0]        kill,
    output logic [N-1:0][N-1:0] older
);
    // older[i][j] = 1 : slot j was accepted before slot i
    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (alloc[i]) older[i] <= valid_q & ~kill;
                else          older[i] <= older[i] & ~alloc;
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = i + 1; j < N; j++) begin : g_col
            AST_AGE_ORDER: assert property (@(posedge clk) disable iff (rst)
                !(valid_q[i] && valid_q[j] && older[i][j] && older[j][i])); // R3
        end
    end
endmodule

// File: rtl/ioq_pick.sv
module ioq_pick #(
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        req,
    input  logic [N-1:0][N-1:0] older,
    output logic [N-1:0]        gnt
);
    for (genvar i = 0; i < N; i++) begin : g_gnt
        assign gnt[i] = req[i] && ((req & older[i]) == '0);
    end

    AST_PICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R3
    AST_PICK_LIVE: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> (gnt != '0)); // R3
endmodule

// File: rtl/ioq_hazard.sv
module ioq_hazard import ioq_pkg::*; #(
    parameter int N  = 8,
    parameter int AW = 32
) (
    input  logic [N-1:0]         valid,
    input  meta_t                meta [N],
    input  logic [N-1:0][AW-1:0] addr,
    input  logic [N-1:0][N-1:0]  older,
    output logic [N-1:0]         issue_req,
    output logic [N-1:0]         retire_req
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic blk;
        logic strict_pend;
        logic any_old;

        always_comb begin
            blk         = 1'b0;
            strict_pend = 1'b0;
            any_old     = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && valid[j] && older[i][j]) begin
                    any_old = 1'b1;
                    case (meta[j].kind)
                        K_SYNC: begin
                            blk         = 1'b1;
                            strict_pend = 1'b1;
                        end
                        K_LBAR: begin
                            if (meta[i].strict) blk = 1'b1;
                        end
                        default: begin
                            if (meta[j].st == S_WAIT &&
                                bytes_overlap(64'(addr[i]), meta[i].size, 64'(addr[j]), meta[j].size))
                                blk = 1'b1;
                            if (meta[j].strict && meta[j].st != S_DONE)
                                strict_pend = 1'b1;
                        end
                    endcase
                end
            end
        end

        assign issue_req[i] = valid[i] && meta[i].kind == K_ACC && meta[i].st == S_WAIT && !blk;

        always_comb begin
            retire_req[i] = 1'b0;
            if (valid[i]) begin
                case (meta[i].kind)
                    K_ACC:   retire_req[i] = (meta[i].st == S_DONE);
                    K_LBAR:  retire_req[i] = !strict_pend;
                    default: retire_req[i] = !any_old;
                endcase
            end
        end
    end
endmodule

// File: rtl/ioq_order_queue.sv
module ioq_order_queue import ioq_pkg::*; #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 64,
    parameter int IDW   = 8,
    localparam int TW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [1:0]     in_kind,
    input  logic [AW-1:0]  in_addr,
    input  logic [DW-1:0]  in_data,
    input  logic [1:0]     in_size,
    input  logic           in_wr,
    input  logic           in_inhib,
    input  logic           in_guard,
    input  logic [IDW-1:0] in_id,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    output logic [DW-1:0]  mem_req_data,
    output logic [1:0]     mem_req_size,
    output logic           mem_req_wr,
    output logic [TW-1:0]  mem_req_tag,
    input  logic           mem_rsp_valid,
    input  logic [TW-1:0]  mem_rsp_tag,
    input  logic [DW-1:0]  mem_rsp_rdata,
    output logic           ack_valid,
    output logic [IDW-1:0] ack_id,
    output logic [1:0]     ack_kind,
    output logic [DW-1:0]  ack_rdata
);
    logic [DEPTH-1:0]             valid_q;
    meta_t                        meta_q  [DEPTH];
    logic [DEPTH-1:0][AW-1:0]     addr_q;
    logic [DW-1:0]                data_q  [DEPTH];
    logic [DW-1:0]                rdata_q [DEPTH];
    logic [IDW-1:0]               id_q    [DEPTH];

    logic [DEPTH-1:0]             alloc_oh, alloc_fire;
    logic [DEPTH-1:0][DEPTH-1:0]  older;
    logic [DEPTH-1:0]             issue_req, retire_req, issue_gnt, ack_gnt;
    logic                         issue_fire;
    logic [TW-1:0]                iss_idx, ack_idx;

    // lowest free slot takes the next operation
    always_comb begin
        alloc_oh = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                alloc_oh    = '0;
                alloc_oh[i] = 1'b1;
            end
        end
    end

    assign in_ready   = !(&valid_q);
    assign alloc_fire = alloc_oh & {DEPTH{in_valid && in_ready}};

    ioq_age #(.N(DEPTH)) u_age (
        .clk(clk), .rst(rst), .valid_q(valid_q), .alloc(alloc_fire),
        .kill(ack_gnt), .older(older)
    );

    ioq_hazard #(.N(DEPTH), .AW(AW)) u_hazard (
        .valid(valid_q), .meta(meta_q), .addr(addr_q), .older(older),
        .issue_req(issue_req), .retire_req(retire_req)
    );

    ioq_pick #(.N(DEPTH)) u_pick_issue (
        .clk(clk), .rst(rst), .req(issue_req), .older(older), .gnt(issue_gnt)
    );

    ioq_pick #(.N(DEPTH)) u_pick_ack (
        .clk(clk), .rst(rst), .req(retire_req), .older(older), .gnt(ack_gnt)
    );

    // memory request mux
    always_comb begin
        mem_req_addr = '0;
        mem_req_data = '0;
        mem_req_size = '0;
        mem_req_wr   = 1'b0;
        iss_idx      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (issue_gnt[i]) begin
                mem_req_addr = addr_q[i];
                mem_req_data = data_q[i];
                mem_req_size = meta_q[i].size;
                mem_req_wr   = meta_q[i].wr;
                iss_idx      = TW'(i);
            end
        end
    end

    assign mem_req_valid = |issue_gnt;
    assign mem_req_tag   = iss_idx;
    assign issue_fire    = mem_req_valid && mem_req_ready;

    // completion mux
    always_comb begin
        ack_id    = '0;
        ack_kind  = 2'd0;
        ack_rdata = '0;
        ack_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ack_gnt[i]) begin
                ack_id    = id_q[i];
                ack_kind  = meta_q[i].kind;
                ack_rdata = rdata_q[i];
                ack_idx   = TW'(i);
            end
        end
    end

    assign ack_valid = |ack_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int i = 0; i < DEPTH; i++) meta_q[i] <= META_RST;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_fire[i]) begin
                    valid_q[i] <= 1'b1;
                    meta_q[i]  <= '{kind: kind_decode(in_kind), st: S_WAIT, size: in_size,
                                    wr: in_wr, strict: in_inhib | in_guard};
                    addr_q[i]  <= in_addr;
                    data_q[i]  <= in_data;
                    id_q[i]    <= in_id;
                    rdata_q[i] <= '0;
                end else begin
                    if (ack_gnt[i]) valid_q[i] <= 1'b0;
                    if (issue_fire && issue_gnt[i]) meta_q[i].st <= S_ISSUED;
                    if (mem_rsp_valid && mem_rsp_tag == TW'(i)) begin
                        meta_q[i].st <= S_DONE;
                        rdata_q[i]   <= mem_rsp_rdata;
                    end
                end
            end
        end
    end

    // ---------------- assertions ----------------
    logic [DEPTH-1:0] iss_older, ack_older;
    logic             iss_sync_old, iss_lbar_old, ack_strict_pend;

    assign iss_older = older[iss_idx] & valid_q;
    assign ack_older = older[ack_idx] & valid_q;

    always_comb begin
        iss_sync_old    = 1'b0;
        iss_lbar_old    = 1'b0;
        ack_strict_pend = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (iss_older[j] && meta_q[j].kind == K_SYNC) iss_sync_old = 1'b1;
            if (iss_older[j] && meta_q[j].kind == K_LBAR) iss_lbar_old = 1'b1;
            if (ack_older[j] && meta_q[j].kind == K_ACC && meta_q[j].strict && meta_q[j].st != S_DONE)
                ack_strict_pend = 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |=> (valid_q == $past(valid_q & ~ack_gnt))); // R2
    AST_RSP_MATCH: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid |-> (valid_q[mem_rsp_tag] && meta_q[mem_rsp_tag].st == S_ISSUED)); // R9
    AST_STRICT_BEHIND_LBAR: assert property (@(posedge clk) disable iff (rst)
        (issue_fire && meta_q[iss_idx].strict) |-> !iss_lbar_old); // R5
    AST_SYNC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        issue_fire |-> !iss_sync_old); // R7
    AST_SYNC_ACK_OLDEST: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_kind == 2'd2) |-> ($countones(ack_older) == 0)); // R7
    AST_LBAR_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && ack_kind == 2'd1) |-> !ack_strict_pend); // R6
    AST_ACK_FREES: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !valid_q[$past(ack_idx)] || $past(alloc_fire[ack_idx])); // R9
endmodule

// File: tb/ioq_order_queue_tb.sv
module ioq_order_queue_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8, AW = 32, DW = 64, IDW = 8, TW = 3, LAT = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 0, in_ready, in_wr = 0, in_inhib = 0, in_guard = 0;
    logic [1:0] in_kind = 0, in_size = 0;
    logic [AW-1:0] in_addr = 0;
    logic [DW-1:0] in_data = 0;
    logic [IDW-1:0] in_id = 0;
    logic mem_req_valid, mem_req_ready = 0, mem_req_wr;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_data;
    logic [1:0] mem_req_size;
    logic [TW-1:0] mem_req_tag;
    logic mem_rsp_valid = 0;
    logic [TW-1:0] mem_rsp_tag = 0;
    logic [DW-1:0] mem_rsp_rdata = 0;
    logic ack_valid;
    logic [IDW-1:0] ack_id;
    logic [1:0] ack_kind;
    logic [DW-1:0] ack_rdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ioq_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .IDW(IDW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_addr(in_addr), .in_data(in_data), .in_size(in_size), .in_wr(in_wr),
        .in_inhib(in_inhib), .in_guard(in_guard), .in_id(in_id),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_req_size(mem_req_size), .mem_req_wr(mem_req_wr),
        .mem_req_tag(mem_req_tag), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_rdata(mem_rsp_rdata), .ack_valid(ack_valid), .ack_id(ack_id),
        .ack_kind(ack_kind), .ack_rdata(ack_rdata)
    );

    typedef struct {
        int kind; logic [AW-1:0] addr; logic [1:0] size; bit wr; bit inh; bit grd;
        logic [IDW-1:0] id; logic [DW-1:0] data; int st; int tag; logic [DW-1:0] rdata;
    } ment_t;
    typedef struct { int tag; int due; logic [DW-1:0] rd; } rsp_t;

    ment_t mq[$];
    ment_t pend[$];
    rsp_t  rq[$];
    logic [DW-1:0] memv [logic [AW-1:0]];
    logic [AW-1:0] issue_log[$];
    logic [IDW-1:0] ack_log[$];
    int errors = 0, checks = 0, cyc = 0, stall_pct = 0;
    bit hold_mem = 0;
    logic [IDW-1:0] next_id = 0;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit m_overlap(ment_t a, ment_t b);
        longint na = 1 << a.size, nb = 1 << b.size;
        return (longint'(a.addr) < longint'(b.addr) + nb) && (longint'(b.addr) < longint'(a.addr) + na);
    endfunction

    function automatic int m_pick_issue();
        for (int i = 0; i < mq.size(); i++) begin
            if (mq[i].kind == 0 && mq[i].st == 0) begin
                bit ok = 1;
                for (int j = 0; j < i; j++) begin
                    if (mq[j].kind == 2) ok = 0;
                    else if (mq[j].kind == 1 && (mq[i].inh || mq[i].grd)) ok = 0;
                    else if (mq[j].kind == 0 && mq[j].st == 0 && m_overlap(mq[i], mq[j])) ok = 0;
                end
                if (ok) return i;
            end
        end
        return -1;
    endfunction

    function automatic int m_pick_ack();
        for (int i = 0; i < mq.size(); i++) begin
            if (mq[i].kind == 0 && mq[i].st == 2) return i;
            if (mq[i].kind == 2 && i == 0) return i;
            if (mq[i].kind == 1) begin
                bit ok = 1;
                for (int j = 0; j < i; j++) begin
                    if (mq[j].kind == 2) ok = 0;
                    if (mq[j].kind == 0 && (mq[j].inh || mq[j].grd) && mq[j].st != 2) ok = 0;
                end
                if (ok) return i;
            end
        end
        return -1;
    endfunction

    task automatic push(int kind, logic [AW-1:0] addr, logic [1:0] size, bit wr, bit inh, bit grd);
        ment_t e;
        e.kind = kind; e.addr = addr; e.size = size; e.wr = wr; e.inh = inh; e.grd = grd;
        e.id = next_id; e.data = {$urandom, $urandom}; e.st = 0; e.tag = 0; e.rdata = '0;
        next_id++;
        pend.push_back(e);
    endtask

    // one clock: drive, compare against the model, advance the model
    task automatic step();
        int ii, ai;
        bit exp_rdy;
        @(negedge clk);
        cyc++;
        in_valid = pend.size() > 0;
        if (pend.size() > 0) begin
            in_kind = 2'(pend[0].kind); in_addr = pend[0].addr; in_size = pend[0].size;
            in_wr = pend[0].wr; in_inhib = pend[0].inh; in_guard = pend[0].grd;
            in_id = pend[0].id; in_data = pend[0].data;
        end
        mem_req_ready = !hold_mem && (($urandom % 100) >= stall_pct);
        mem_rsp_valid = rq.size() > 0 && rq[0].due <= cyc;
        if (mem_rsp_valid) begin
            mem_rsp_tag = TW'(rq[0].tag);
            mem_rsp_rdata = rq[0].rd;
        end
        #1;
        exp_rdy = mq.size() < DEPTH;
        ii = m_pick_issue();
        ai = m_pick_ack();
        chk("R2", "in_ready", in_ready, exp_rdy);
        chk("R3", "mem_req_valid", mem_req_valid, ii >= 0);
        if (ii >= 0 && mem_req_valid) begin
            chk("R3", "mem_req_addr", mem_req_addr, mq[ii].addr);
            chk("R3", "mem_req_data", mem_req_data, mq[ii].data);
            chk("R3", "mem_req_wr", mem_req_wr, mq[ii].wr);
        end
        chk("R9", "ack_valid", ack_valid, ai >= 0);
        if (ai >= 0 && ack_valid) begin
            chk("R9", "ack_id", ack_id, mq[ai].id);
            chk("R9", "ack_rdata", ack_rdata, mq[ai].rdata);
            chk("R11", "ack_kind", ack_kind, mq[ai].kind);
        end
        // model advance for the coming rising edge
        if (mem_rsp_valid) begin
            foreach (mq[k]) if (mq[k].st == 1 && mq[k].tag == rq[0].tag) begin
                mq[k].st = 2; mq[k].rdata = rq[0].rd;
            end
            void'(rq.pop_front());
        end
        if (ii >= 0 && mem_req_ready) begin
            rsp_t r;
            mq[ii].st = 1;
            mq[ii].tag = int'(mem_req_tag);
            issue_log.push_back(mq[ii].addr);
            if (mq[ii].wr) begin
                memv[mq[ii].addr] = mq[ii].data; r.rd = '0;
            end else begin
                r.rd = memv.exists(mq[ii].addr) ? memv[mq[ii].addr] : {~mq[ii].addr, mq[ii].addr};
            end
            r.tag = mq[ii].tag; r.due = cyc + LAT;
            rq.push_back(r);
        end
        if (ai >= 0) begin
            ack_log.push_back(mq[ai].id);
            mq.delete(ai);
        end
        if (in_valid && exp_rdy) mq.push_back(pend.pop_front());
    endtask

    task automatic drain();
        for (int n = 0; n < 3000; n++) begin
            if (mq.size() == 0 && pend.size() == 0 && rq.size() == 0) return;
            step();
        end
        chk("R9", "drain completes", 0, 1);
    endtask

    task automatic chk_order(string req, logic [AW-1:0] exp[$]);
        chk(req, "issue count", issue_log.size(), exp.size());
        foreach (exp[k]) if (k < issue_log.size()) chk(req, "issue order", issue_log[k], exp[k]);
    endtask

    function automatic int ack_pos(logic [IDW-1:0] id);
        foreach (ack_log[k]) if (ack_log[k] == id) return k;
        return -1;
    endfunction

    initial begin
        logic [IDW-1:0] b0;
        int base;
        repeat (3) @(negedge clk);
        #1;
        // R1: empty during reset
        chk("R1", "in_ready in reset", in_ready, 1);
        chk("R1", "mem_req_valid in reset", mem_req_valid, 0);
        chk("R1", "ack_valid in reset", ack_valid, 0);
        rst = 1'b0;
        step();

        // R4 R5 R6: cacheable read passes a held device store
        issue_log.delete(); ack_log.delete(); b0 = next_id;
        push(0, 32'h100, 2, 1, 1, 0);
        push(1, 0, 0, 0, 0, 0);
        push(0, 32'h200, 2, 1, 0, 1);
        push(0, 32'h300, 2, 0, 0, 0);
        drain();
        chk_order("R4", '{32'h100, 32'h300, 32'h200});
        chk("R6", "light barrier acked after older device access", ack_pos(b0 + 1) > ack_pos(b0), 1);
        chk("R5", "device access acked after barrier", ack_pos(b0 + 2) > ack_pos(b0 + 1), 1);

        // R7: full barrier drains and holds younger cacheable work
        issue_log.delete(); ack_log.delete(); b0 = next_id;
        push(0, 32'h400, 3, 1, 0, 0);
        push(2, 0, 0, 0, 0, 0);
        push(0, 32'h500, 3, 0, 0, 0);
        drain();
        chk_order("R7", '{32'h400, 32'h500});
        chk("R7", "ack order older", ack_pos(b0 + 1), 1);
        chk("R7", "ack order younger", ack_pos(b0 + 2), 2);

        // R8: cacheable read overlapping a held device store waits behind it
        issue_log.delete(); ack_log.delete(); b0 = next_id;
        push(0, 32'h600, 2, 1, 1, 0);
        push(1, 0, 0, 0, 0, 0);
        push(0, 32'h700, 3, 1, 1, 1);
        push(0, 32'h704, 2, 0, 0, 0);
        drain();
        chk_order("R8", '{32'h600, 32'h700, 32'h704});

        // R10: fenced device stores under back-pressure
        issue_log.delete(); stall_pct = 50;
        for (int k = 0; k < 4; k++) begin
            push(0, 32'h800 + 32'(k * 8), 3, 1, k[0], !k[0]);
            push(0, 32'h900 + 32'(k * 8), 3, 0, 0, 0);
            push(1, 0, 0, 0, 0, 0);
        end
        drain();
        begin
            logic [AW-1:0] dev[$];
            foreach (issue_log[k]) if (issue_log[k] < 32'h900) dev.push_back(issue_log[k]);
            chk("R10", "device store count", dev.size(), 4);
            foreach (dev[k]) chk("R10", "device store order", dev[k], 32'h800 + 32'(k * 8));
        end
        stall_pct = 0;

        // R2: full queue refuses, then accepts the surplus
        ack_log.delete(); hold_mem = 1;
        for (int k = 0; k < 10; k++) push(0, 32'hA00 + 32'(k * 8), 3, 1, 0, 0);
        repeat (12) step();
        chk("R2", "in_ready low when full", in_ready, 0);
        chk("R2", "surplus held outside", pend.size(), 2);
        chk("R2", "no ack while memory stalled", ack_log.size(), 0);
        hold_mem = 0;
        drain();
        chk("R2", "all ten acknowledged", ack_log.size(), 10);

        // R11 and mixed traffic: random kinds, attributes, overlaps, stalls
        ack_log.delete(); stall_pct = 30; base = next_id;
        for (int k = 0; k < 250; k++) begin
            int r = $urandom % 10;
            logic [1:0] sz = 2'($urandom % 4);
            logic [AW-1:0] a = (32'($urandom % 64)) & ~((32'd1 << sz) - 1);
            if (r == 0) push(1, 0, 0, 0, 0, 0);
            else if (r == 1) push(2 + ($urandom % 2), 0, 0, 0, 0, 0);
            else push(0, a, sz, $urandom % 2, ($urandom % 3) == 0, ($urandom % 4) == 0);
        end
        drain();
        chk("R11", "every random operation acknowledged", ack_log.size(), next_id - IDW'(base) + ((next_id < IDW'(base)) ? 256 : 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule